// File: doc/BRIEF.md
# Bit-Serial Binary-Weight Neuron with Fused Normalize-and-Quantize

This block computes a single output activation of a quantized network layer. Each cycle it may accept one window of small unsigned activations together with an equal-length vector of one-bit weights and the two normalization coefficients of the output channel. Multiplication is never performed. Instead, every bit-plane of the activations is compared with the weight vector by XNOR. The agreements are counted. Each plane's signed dot product is scaled by its binary weight, and the planes are summed.

The sum passes through a signed fixed-point scale and offset, then a round-to-nearest step. It is then saturated into a two-bit unsigned code, which feeds the next layer. The datapath is a three-stage pipeline that accepts a new window on every cycle. Forming the window and loading the weights are done outside the block.

Top module: `xnp_neuron`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` and `out_code` are 0 until a window has passed through the pipeline.
- R2: A window presented with `in_valid` high in cycle c produces `out_valid` high in cycle c+3 and not earlier. Windows on consecutive cycles produce results on consecutive cycles, in the same order.
- R3: Element i of the window occupies `in_act[i*ACT_W +: ACT_W]`. Weight bit 1 means +1 and weight bit 0 means −1. Within bit-plane p, activation bit 1 counts as +1 and 0 counts as −1. Plane p contributes 2^p·(2·a_p − N_IN), where a_p is the number of positions whose activation bit equals the weight bit. The sum s is the total over all planes.
- R4: With t = s·`in_scale` + `in_offset` (both signed two's complement), the result before clipping is floor((t + 2^(FRAC−1)) / 2^FRAC). With FRAC = 4, t = 24 gives 2 and t = 23 gives 1.
- R5: A negative result before clipping gives `out_code` = 0.
- R6: A result before clipping above 3 gives `out_code` = 3.
- R7: The scale and offset are sampled in the same cycle as the window. Changing them in later cycles does not alter that window's result.
- R8: In a cycle where no result emerges, `out_valid` is 0 and `out_code` keeps its last value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window qualifier |
| in_act | input | N_IN*ACT_W | Packed unsigned activations of the window |
| in_weight | input | N_IN | One-bit weights, 1 = +1, 0 = −1 |
| in_scale | input | SCALE_W | Signed channel scale, FRAC fractional bits |
| in_offset | input | OFF_W | Signed channel offset, FRAC fractional bits |
| out_valid | output | 1 | Result qualifier |
| out_code | output | 2 | Quantized activation, 0 to 3 |

## Verification
The bench targets the rounding boundary where t moves from 23 to 24. A design that truncates instead of rounding returns 1 where 2 is expected. Windows with all planes agreeing and all planes disagreeing test the plane weighting and the −N bias. A design that drops the bias, or weights the planes the wrong way round, gives wrong codes in those cases. A negative scale and large offsets of both signs test saturation, where a wrap to the low two bits would show up. A back-to-back stream, a check that no result appears early, and coefficient changes after a window test latency, ordering and coefficient capture. Idle cycles with moving inputs catch an output register that is not held.

// File: rtl/xnp_pkg.sv
package xnp_pkg;
    typedef logic [1:0] qcode_t;
    localparam int QCODE_MAX = 3;
endpackage

// File: rtl/xnp_plane_stage.sv
module xnp_plane_stage #(
    parameter int N_IN    = 27,
    parameter int ACT_W   = 2,
    parameter int SCALE_W = 8,
    parameter int OFF_W   = 12,
    localparam int PC_W   = $clog2(N_IN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [N_IN*ACT_W-1:0]     in_act,
    input  logic [N_IN-1:0]           in_weight,
    input  logic signed [SCALE_W-1:0] in_scale,
    input  logic signed [OFF_W-1:0]   in_offset,
    output logic                      s1_valid,
    output logic [ACT_W*PC_W-1:0]     s1_count,
    output logic signed [SCALE_W-1:0] s1_scale,
    output logic signed [OFF_W-1:0]   s1_offset
);
    typedef struct packed {
        logic                      v;
        logic [ACT_W*PC_W-1:0]     cnt;
        logic signed [SCALE_W-1:0] sc;
        logic signed [OFF_W-1:0]   off;
    } st1_t;

    st1_t st_d, st_q;
    logic [ACT_W*PC_W-1:0] cnt_all;

    // one agreement counter per activation bit-plane
    for (genvar p = 0; p < ACT_W; p++) begin : g_plane
        logic [N_IN-1:0] agree;
        logic [PC_W-1:0] tally;
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                agree[i] = ~(in_act[i*ACT_W + p] ^ in_weight[i]);
            end
            tally = '0;
            for (int i = 0; i < N_IN; i++) begin
                tally = tally + PC_W'(agree[i]);
            end
        end
        assign cnt_all[p*PC_W +: PC_W] = tally;
    end

    always_comb begin
        st_d   = st_q;
        st_d.v = in_valid;
        if (in_valid) begin
            st_d.cnt = cnt_all;
            st_d.sc  = in_scale;
            st_d.off = in_offset;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid  = st_q.v;
    assign s1_count  = st_q.cnt;
    assign s1_scale  = st_q.sc;
    assign s1_offset = st_q.off;
endmodule

// File: rtl/xnp_accum_norm.sv
module xnp_accum_norm #(
    parameter int N_IN    = 27,
    parameter int ACT_W   = 2,
    parameter int SCALE_W = 8,
    parameter int OFF_W   = 12,
    localparam int PC_W   = $clog2(N_IN + 1),
    localparam int ACC_W  = $clog2(((2**ACT_W) - 1) * N_IN + 1) + 1,
    localparam int MUL_W  = ACC_W + SCALE_W,
    localparam int T_W    = ((MUL_W > OFF_W) ? MUL_W : OFF_W) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s1_valid,
    input  logic [ACT_W*PC_W-1:0]     s1_count,
    input  logic signed [SCALE_W-1:0] s1_scale,
    input  logic signed [OFF_W-1:0]   s1_offset,
    output logic                      s2_valid,
    output logic signed [T_W-1:0]     s2_t
);
    localparam logic signed [ACC_W-1:0] N_S = ACC_W'(N_IN);

    typedef struct packed {
        logic                  v;
        logic signed [T_W-1:0] t;
    } st2_t;

    st2_t st_d, st_q;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] term;
    logic signed [T_W-1:0]   sx, cx, ox;

    always_comb begin
        sum  = '0;
        term = '0;
        for (int p = 0; p < ACT_W; p++) begin
            term = $signed({{(ACC_W-PC_W){1'b0}}, s1_count[p*PC_W +: PC_W]});
            term = (term <<< 1) - N_S;
            sum  = sum + (term <<< p);
        end
        sx = T_W'(sum);
        cx = T_W'(s1_scale);
        ox = T_W'(s1_offset);
        st_d   = st_q;
        st_d.v = s1_valid;
        if (s1_valid) begin
            st_d.t = sx * cx + ox;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s2_valid = st_q.v;
    assign s2_t     = st_q.t;

    a_r2_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> s2_valid);
endmodule

// File: rtl/xnp_quant.sv
module xnp_quant
    import xnp_pkg::*;
#(
    parameter int T_W  = 17,
    parameter int FRAC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s2_valid,
    input  logic signed [T_W-1:0] s2_t,
    output logic                  q_valid,
    output qcode_t                q_code
);
    localparam logic signed [T_W-1:0] HALF = T_W'(1 << (FRAC - 1));
    localparam logic signed [T_W-1:0] TOP  = T_W'(QCODE_MAX);

    typedef struct packed {
        logic   v;
        qcode_t code;
    } st3_t;

    st3_t st_d, st_q;
    logic signed [T_W-1:0] rnd;
    logic                  too_low, too_high;

    always_comb begin
        rnd      = (s2_t + HALF) >>> FRAC;
        too_low  = rnd < 0;
        too_high = rnd > TOP;
        st_d     = st_q;
        st_d.v   = s2_valid;
        if (s2_valid) begin
            if (too_low)       st_d.code = '0;
            else if (too_high) st_d.code = qcode_t'(QCODE_MAX);
            else               st_d.code = rnd[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_valid = st_q.v;
    assign q_code  = st_q.code;

    a_r5_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && too_low) |=> (q_code == 2'd0));
    a_r6_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && too_high) |=> (q_code == 2'd3));
    a_r8_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> $stable(q_code));
endmodule

// File: rtl/xnp_neuron.sv
module xnp_neuron
    import xnp_pkg::*;
#(
    parameter int N_IN    = 27,
    parameter int ACT_W   = 2,
    parameter int SCALE_W = 8,
    parameter int OFF_W   = 12,
    parameter int FRAC    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [N_IN*ACT_W-1:0]     in_act,
    input  logic [N_IN-1:0]           in_weight,
    input  logic signed [SCALE_W-1:0] in_scale,
    input  logic signed [OFF_W-1:0]   in_offset,
    output logic                      out_valid,
    output logic [1:0]                out_code
);
    localparam int PC_W  = $clog2(N_IN + 1);
    localparam int ACC_W = $clog2(((2**ACT_W) - 1) * N_IN + 1) + 1;
    localparam int MUL_W = ACC_W + SCALE_W;
    localparam int T_W   = ((MUL_W > OFF_W) ? MUL_W : OFF_W) + 1;

    logic                      s1_valid;
    logic [ACT_W*PC_W-1:0]     s1_count;
    logic signed [SCALE_W-1:0] s1_scale;
    logic signed [OFF_W-1:0]   s1_offset;
    logic                      s2_valid;
    logic signed [T_W-1:0]     s2_t;
    qcode_t                    code_q;

    xnp_plane_stage #(.N_IN(N_IN), .ACT_W(ACT_W), .SCALE_W(SCALE_W), .OFF_W(OFF_W)) i_plane (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_act(in_act),
        .in_weight(in_weight), .in_scale(in_scale), .in_offset(in_offset),
        .s1_valid(s1_valid), .s1_count(s1_count), .s1_scale(s1_scale), .s1_offset(s1_offset)
    );

    xnp_accum_norm #(.N_IN(N_IN), .ACT_W(ACT_W), .SCALE_W(SCALE_W), .OFF_W(OFF_W)) i_norm (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_count(s1_count),
        .s1_scale(s1_scale), .s1_offset(s1_offset), .s2_valid(s2_valid), .s2_t(s2_t)
    );

    xnp_quant #(.T_W(T_W), .FRAC(FRAC)) i_quant (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_t(s2_t),
        .q_valid(out_valid), .q_code(code_q)
    );

    assign out_code = code_q;
endmodule

// File: tb/test_xnp_neuron.sv
module test_xnp_neuron;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 27;
    localparam int AW = 2;

    typedef struct packed {
        logic [N*AW-1:0]    a;
        logic [N-1:0]       w;
        logic signed [7:0]  sc;
        logic signed [11:0] off;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{54'h0,              27'h7FFFFFF,  8'sd1,   12'sd0},
        '{54'h3FFFFFFFFFFFFF, 27'h7FFFFFF,  8'sd2,   12'sd0},
        '{54'h3FFFFFFFFFFFFF, 27'h0,       -8'sd1,   12'sd0},
        '{54'h2AAAAAAAAAAAAA, 27'h5555555,  8'sd3,  -12'sd20},
        '{54'h1B6DB6DB6DB6DB, 27'h3A5C3F1,  8'sd5,   12'sd40},
        '{54'h0F0F0F0F0F0F0F, 27'h7FFF000, -8'sd4,   12'sd100},
        '{54'h3123456789ABCD, 27'h1234567,  8'sd1,   12'sd24},
        '{54'h15555555555555, 27'h7FFFFFF,  8'sd1,   12'sd8}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [N*AW-1:0] in_act = '0;
    logic [N-1:0] in_weight = '0;
    logic signed [7:0] in_scale = '0;
    logic signed [11:0] in_offset = '0;
    logic out_valid;
    logic [1:0] out_code;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xnp_neuron i_xnp_neuron (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_act(in_act),
        .in_weight(in_weight), .in_scale(in_scale), .in_offset(in_offset),
        .out_valid(out_valid), .out_code(out_code)
    );

    // model built from R3, R4, R5, R6
    function automatic int ref_code(logic [N*AW-1:0] a, logic [N-1:0] w, int sc, int off);
        int s = 0;
        for (int p = 0; p < AW; p++) begin
            int agree = 0;
            for (int i = 0; i < N; i++) agree += (a[i*AW+p] == w[i]) ? 1 : 0;
            s += (2*agree - N) * (1 << p);
        end
        begin
            int t = s*sc + off;
            int r = (t + 8) >>> 4;
            if (r < 0) r = 0;
            if (r > 3) r = 3;
            return r;
        end
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v, logic vld);
        in_valid  = vld;
        in_act    = v.a;
        in_weight = v.w;
        in_scale  = v.sc;
        in_offset = v.off;
    endtask

    task automatic single(vec_t v, int exp, string req);
        @(negedge clk); drive(v, 1'b1);
        @(negedge clk); in_valid = 0;
        @(negedge clk); chk("R2 no early result", int'(out_valid), 0);
        @(negedge clk); chk(req, int'(out_valid), 1); chk(req, int'(out_code), exp);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 code in reset", int'(out_code), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 code after reset", int'(out_code), 0);

        // R2, R3 back-to-back stream from the vector table
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk("R2 stream valid", int'(out_valid), 1);
                chk("R3 stream code", int'(out_code),
                    ref_code(VECS[i-3].a, VECS[i-3].w, int'(VECS[i-3].sc), int'(VECS[i-3].off)));
            end
            if (i < NV) drive(VECS[i], 1'b1);
            else        in_valid = 0;
        end
        @(negedge clk);
        chk("R2 stream ends", int'(out_valid), 0);

        // R3 hand-derived: all ones, all +1 weights gives s = 81
        v = '{54'h3FFFFFFFFFFFFF, 27'h7FFFFFF, 8'sd1, -12'sd50};
        single(v, 2, "R3 full agreement t=31");
        // R4 rounding boundary
        v.off = -12'sd57;
        single(v, 2, "R4 t=24 rounds up");
        v.off = -12'sd58;
        single(v, 1, "R4 t=23 rounds down");
        // R6 and R5 saturation
        v.off = 12'sd2000;
        single(v, 3, "R6 high clip");
        v.off = -12'sd2000;
        single(v, 0, "R5 low clip");
        v = '{54'h0, 27'h7FFFFFF, 8'sd1, 12'sd0};
        single(v, 0, "R5 s=-81 clip");

        // R7 coefficients captured with window
        v = '{54'h3FFFFFFFFFFFFF, 27'h7FFFFFF, 8'sd1, -12'sd57};
        @(negedge clk); drive(v, 1'b1);
        @(negedge clk); in_valid = 0; in_scale = -8'sd128; in_offset = -12'sd2048;
        @(negedge clk); in_scale = 8'sd127; in_offset = 12'sd2047;
        @(negedge clk);
        chk("R7 valid", int'(out_valid), 1);
        chk("R7 coefficient capture", int'(out_code), 2);

        // R8 idle cycles hold the code
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_act = ~in_act; in_weight = ~in_weight; in_offset = 12'sd2000;
            chk("R8 idle valid", int'(out_valid), 0);
            chk("R8 held code", int'(out_code), 2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule